// File: doc/BRIEF.md
# Receive Word Boundary Aligner

This block sits behind a clock-recovery stage and turns a recovered serial bit stream into 34-bit words: a 32-bit data part and a 2-bit type field. Bits arrive one per cycle in which `bit_valid` is high. While the link is not yet locked, the block searches for the word boundary. It compares every assembled word with a fixed alignment word. After each miss it moves its boundary by one bit position. It does nothing until a link-initialization request is raised.

After a run of matching alignment words, the block declares lock. It drives its active-low receive-OK output low and raises a one-cycle pulse that starts alignment on the transmit side. From then on, every assembled word goes out on a valid/ready stream.

The serial input cannot be stalled and has no ready. On the output side, a word stays in a one-entry register with `out_valid` high until `out_ready` is seen high at a clock edge. If the next word finishes while the held word is still waiting, the new word is discarded and the held word is kept unchanged. A locked link returns to the search state when too many consecutive words are unusable.

Top module: `rx_word_aligner`

## Requirements
- R1: A word is 34 bits long. The first bit received becomes bit 33. Bits [33:32] are the type field and appear on `out_type`; bits [31:0] appear on `out_data`. The first word boundary falls after the first 34 bits following reset.
- R2: While searching, each assembled word that differs from the alignment word (default 34'h3F6A13C05) moves the boundary one bit later. The next word tested ends 35 bits after the word that missed, so no partial word is ever tested.
- R3: Lock is declared after 2 consecutive words equal the alignment word. `rx_ok_n` goes low one clock after the second match is assembled, and never earlier.
- R4: `tx_align_start` is high for exactly one cycle, and that cycle is the one in which `rx_ok_n` falls.
- R5: While `link_init_req` is low, the block never locks and never slips. Dropping the request during a search returns the block to idle.
- R6: A synchronous reset (`rst` high) gives `rx_ok_n` high, `out_valid` low and `tx_align_start` low, and the block is placed back in the unaligned state.
- R7: While locked, a word counts as bad when it is not the alignment word and its type is 3; types 0, 1 and 2 are valid. Four consecutive bad words drop lock (`rx_ok_n` high) and restart the search. Any good word clears the count.
- R8: While locked, every assembled word is presented once on `out_data`/`out_type` with `out_valid`. The output holds the word, stable, until it is accepted by `out_ready` at a clock edge.
- R9: If a word finishes while the output still holds an unaccepted word, the new word is dropped and the held word is not changed.
- R10: No word is presented while the block is unlocked: `out_valid` rises only in the cycle after one in which `rx_ok_n` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| link_init_req | input | 1 | Enables the boundary search |
| bit_valid | input | 1 | A serial bit is present this cycle |
| bit_in | input | 1 | Serial data bit |
| out_ready | input | 1 | Downstream accepts the output word |
| out_valid | output | 1 | Output word is valid |
| out_data | output | 32 | Data part of the word |
| out_type | output | 2 | Type field of the word |
| rx_ok_n | output | 1 | Low while word-aligned |
| tx_align_start | output | 1 | One-cycle pulse on gaining lock |

## Verification
A word is assembled at the clock edge that takes in its last bit, and its strobe is internal for the following cycle. The lock state, the fall of `rx_ok_n`, the `tx_align_start` pulse and the loading of the output all take effect one edge later, which is two edges after that last bit. The bench drives inputs and samples outputs on the falling edge. It expects the lock flag to change exactly two samples after the final bit of the second matching word, as worked out from the starting bit offset and the one-bit slip per miss. It also checks that the flag stays high in every sample before that point. Output words are compared in the sample where the bench itself raises `out_ready` with `out_valid` high, and each lock-loss or back-pressure result is read three samples after the last bit of the word concerned.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_LOCK   = 2'd2
  } align_state_t;
endpackage

// File: rtl/rxa_word_assembler.sv
// Shifts serial bits into a word-wide window and strobes at each boundary.
// A slip request postpones the next boundary by one bit.
module rxa_word_assembler #(
  parameter int WORD_W    = 34,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              slip_req,
  output logic              word_strb,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q;
  logic              pend_q, strb_q;

  generate
    if (MSB_FIRST) begin : g_msb
      assign sr_d = {sr_q[WORD_W-2:0], bit_in};
    end else begin : g_lsb
      assign sr_d = {bit_in, sr_q[WORD_W-1:1]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      strb_q <= 1'b0;
    end else begin
      strb_q <= 1'b0;
      if (bit_valid) begin
        sr_q <= sr_d;
        if (cnt_q == LAST) begin
          if (pend_q) begin
            pend_q <= 1'b0;          // absorb one extra bit: boundary moves
          end else begin
            strb_q <= 1'b1;
            cnt_q  <= '0;
          end
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
      if (slip_req) pend_q <= 1'b1;
    end
  end

  assign word_strb = strb_q;
  assign word      = sr_q;
endmodule

// File: rtl/rxa_lock_ctrl.sv
// Search / lock state machine with match and bad-word run counters.
module rxa_lock_ctrl
  import rxa_pkg::*;
#(
  parameter int                          WORD_W      = 34,
  parameter int                          TYPE_W      = 2,
  parameter logic [WORD_W-1:0]           ALIGN_WORD  = 34'h3F6A13C05,
  parameter logic [(2**TYPE_W)-1:0]      VALID_TYPES = 4'b0111,
  parameter int                          MATCH_NEED  = 2,
  parameter int                          BAD_LIMIT   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_init_req,
  input  logic              word_strb,
  input  logic [WORD_W-1:0] word,
  output logic              slip_req,
  output logic              locked,
  output logic              tx_align_start
);
  localparam int MC_W = $clog2(MATCH_NEED + 1);
  localparam int BC_W = $clog2(BAD_LIMIT + 1);
  localparam logic [MC_W-1:0] MATCH_LAST = MC_W'(MATCH_NEED - 1);
  localparam logic [BC_W-1:0] BAD_LAST   = BC_W'(BAD_LIMIT - 1);

  align_state_t    state_q;
  logic [MC_W-1:0] match_q;
  logic [BC_W-1:0] bad_q;
  logic            start_q;
  logic            is_align, type_ok, is_bad;

  assign is_align = (word == ALIGN_WORD);
  assign type_ok  = VALID_TYPES[word[WORD_W-1 -: TYPE_W]];
  assign is_bad   = !is_align && !type_ok;
  assign slip_req = (state_q == ST_SEARCH) && link_init_req && word_strb && !is_align;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      match_q <= '0;
      bad_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (link_init_req) begin
            state_q <= ST_SEARCH;
            match_q <= '0;
          end
        end
        ST_SEARCH: begin
          if (!link_init_req) begin
            state_q <= ST_IDLE;
          end else if (word_strb) begin
            if (is_align) begin
              if (match_q == MATCH_LAST) begin
                state_q <= ST_LOCK;
                start_q <= 1'b1;
                match_q <= '0;
                bad_q   <= '0;
              end else begin
                match_q <= match_q + MC_W'(1);
              end
            end else begin
              match_q <= '0;
            end
          end
        end
        ST_LOCK: begin
          if (word_strb) begin
            if (is_bad) begin
              if (bad_q == BAD_LAST) begin
                state_q <= ST_SEARCH;
                bad_q   <= '0;
                match_q <= '0;
              end else begin
                bad_q <= bad_q + BC_W'(1);
              end
            end else begin
              bad_q <= '0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign locked         = (state_q == ST_LOCK);
  assign tx_align_start = start_q;
endmodule

// File: rtl/rxa_out_stage.sv
// One-entry output register; a word arriving while full is discarded.
module rxa_out_stage #(
  parameter int WORD_W = 34
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] in_word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  logic              vld_q;
  logic [WORD_W-1:0] word_q;
  logic              room;

  assign room = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      word_q <= '0;
    end else if (load && room) begin
      vld_q  <= 1'b1;
      word_q <= in_word;
    end else if (vld_q && out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_word  = word_q;
endmodule

// File: rtl/rx_word_aligner.sv
module rx_word_aligner #(
  parameter int                               DATA_W      = 32,
  parameter int                               TYPE_W      = 2,
  parameter logic [DATA_W+TYPE_W-1:0]         ALIGN_WORD  = 34'h3F6A13C05,
  parameter logic [(2**TYPE_W)-1:0]           VALID_TYPES = 4'b0111,
  parameter int                               MATCH_NEED  = 2,
  parameter int                               BAD_LIMIT   = 4,
  parameter bit                               MSB_FIRST   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_init_req,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [TYPE_W-1:0] out_type,
  output logic              rx_ok_n,
  output logic              tx_align_start
);
  localparam int WORD_W = DATA_W + TYPE_W;

  logic              word_strb;
  logic [WORD_W-1:0] word;
  logic              slip_req;
  logic              locked;
  logic [WORD_W-1:0] held_word;

  rxa_word_assembler #(
    .WORD_W    (WORD_W),
    .MSB_FIRST (MSB_FIRST)
  ) asm_i (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .slip_req  (slip_req),
    .word_strb (word_strb),
    .word      (word)
  );

  rxa_lock_ctrl #(
    .WORD_W      (WORD_W),
    .TYPE_W      (TYPE_W),
    .ALIGN_WORD  (ALIGN_WORD),
    .VALID_TYPES (VALID_TYPES),
    .MATCH_NEED  (MATCH_NEED),
    .BAD_LIMIT   (BAD_LIMIT)
  ) ctrl_i (
    .clk            (clk),
    .rst            (rst),
    .link_init_req  (link_init_req),
    .word_strb      (word_strb),
    .word           (word),
    .slip_req       (slip_req),
    .locked         (locked),
    .tx_align_start (tx_align_start)
  );

  rxa_out_stage #(
    .WORD_W (WORD_W)
  ) out_i (
    .clk       (clk),
    .rst       (rst),
    .load      (word_strb && locked),
    .in_word   (word),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_word  (held_word)
  );

  assign out_data = held_word[DATA_W-1:0];
  assign out_type = held_word[WORD_W-1:DATA_W];
  assign rx_ok_n  = !locked;
endmodule

// File: rtl/rx_word_aligner_chk.sv
module rx_word_aligner_chk #(
  parameter int DATA_W = 32,
  parameter int TYPE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              link_init_req,
  input logic              out_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [TYPE_W-1:0] out_type,
  input logic              rx_ok_n,
  input logic              tx_align_start,
  input logic              slip_req
);
  p_slip_unlocked_r2: assert property (@(posedge clk) disable iff (rst)
    slip_req |-> rx_ok_n);

  p_pulse_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    tx_align_start |-> $fell(rx_ok_n));

  p_fall_has_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_ok_n) |-> tx_align_start);

  p_no_lock_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!link_init_req && rx_ok_n) |=> rx_ok_n);

  p_reset_state_r6: assert property (@(posedge clk)
    $past(rst) |-> (rx_ok_n && !out_valid && !tx_align_start));

  p_hold_word_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_type)));

  p_present_locked_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(!rx_ok_n));
endmodule

bind rx_word_aligner rx_word_aligner_chk #(
  .DATA_W (DATA_W),
  .TYPE_W (TYPE_W)
) chk_i (
  .clk            (clk),
  .rst            (rst),
  .link_init_req  (link_init_req),
  .out_ready      (out_ready),
  .out_valid      (out_valid),
  .out_data       (out_data),
  .out_type       (out_type),
  .rx_ok_n        (rx_ok_n),
  .tx_align_start (tx_align_start),
  .slip_req       (slip_req)
);

// File: tb/rx_word_aligner_tb_top.sv
module rx_word_aligner_tb_top;
  localparam logic [33:0] ALIGN = 34'h3F6A13C05;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        link_init_req = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;
  logic [1:0]  out_type;
  logic        rx_ok_n;
  logic        tx_align_start;

  int n_chk = 0;
  int n_bad = 0;
  int nb = 0;
  int nlock = 0;
  int low_run = 0;
  bit watch = 1'b0;
  bit gate_watch = 1'b0;
  bit bp_force = 1'b0;
  bit done = 1'b0;
  logic [33:0] exp_q[$];

  always #4 clk = ~clk;

  rx_word_aligner dut_i (
    .clk            (clk),
    .rst            (rst),
    .link_init_req  (link_init_req),
    .bit_valid      (bit_valid),
    .bit_in         (bit_in),
    .out_ready      (out_ready),
    .out_valid      (out_valid),
    .out_data       (out_data),
    .out_type       (out_type),
    .rx_ok_n        (rx_ok_n),
    .tx_align_start (tx_align_start)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [33:0] rand_data_word();
    logic [1:0] t;
    t = 2'($urandom % 3);
    return {t, 32'($urandom)};
  endfunction

  // One cycle: sample outputs, then drive the next inputs.
  task automatic tick(input logic v, input logic b);
    bit exp_lk;
    bit rdy;
    logic [33:0] e;
    @(negedge clk);
    if (watch) begin
      exp_lk = (nb >= nlock + 2);
      check(rx_ok_n == !exp_lk, "R2 R3 lock timing", 64'(rx_ok_n), 64'(!exp_lk));
      check(tx_align_start == (nb == nlock + 2), "R4 start pulse",
            64'(tx_align_start), 64'(nb == nlock + 2));
      if (!exp_lk) check(!out_valid, "R10 no output unlocked", 64'(out_valid), 64'd0);
    end
    if (gate_watch) begin
      check(rx_ok_n == 1'b1, "R5 gated search", 64'(rx_ok_n), 64'd1);
      check(!out_valid, "R10 no output gated", 64'(out_valid), 64'd0);
    end
    if (bp_force) rdy = 1'b0;
    else rdy = ($urandom % 4 != 0) || (low_run >= 8);
    low_run = rdy ? 0 : low_run + 1;
    if (out_valid && rdy) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected word", 64'({out_type, out_data}), 64'd0);
      end else begin
        e = exp_q.pop_front();
        check({out_type, out_data} == e, "R1/R8 word", 64'({out_type, out_data}), 64'(e));
      end
    end
    out_ready = rdy;
    bit_valid = v;
    bit_in    = b;
    nb++;
  endtask

  task automatic send_word(input logic [33:0] w, input bit gaps);
    for (int i = 33; i >= 0; i--) begin
      if (gaps && ($urandom % 4 == 0)) tick(1'b0, 1'b0);
      tick(1'b1, w[i]);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
  endtask

  task automatic do_reset(input logic req);
    @(negedge clk);
    rst = 1'b1;
    bit_valid = 1'b0;
    link_init_req = req;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    nb = 0;
  endtask

  // Stream starts d bits into an alignment word; expect s = (34-d)%34 slips.
  task automatic run_trial(input int d);
    int s;
    int k_more;
    logic [33:0] w;
    do_reset(1'b1);
    s      = (34 - d) % 34;
    k_more = (d == 0) ? 1 : s + 2;
    nlock  = 33 + 34 * (s + 1) + s;
    watch  = 1'b1;
    for (int i = 33 - d; i >= 0; i--) tick(1'b1, ALIGN[i]);
    for (int k = 0; k < k_more; k++) send_word(ALIGN, 1'b0);
    for (int n = 0; n < 12; n++) begin
      w = rand_data_word();
      exp_q.push_back(w);
      send_word(w, 1'b1);
    end
    idle(6);
    watch = 1'b0;
    check(exp_q.size() == 0, "R8 all words delivered", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    logic [33:0] wa, wb, wc, wd, w;
    void'($urandom(32'd4242));

    // R6: reset state
    do_reset(1'b1);
    check(rx_ok_n == 1'b1, "R6 rx_ok_n", 64'(rx_ok_n), 64'd1);
    check(!out_valid, "R6 out_valid", 64'(out_valid), 64'd0);
    check(!tx_align_start, "R6 tx_align_start", 64'(tx_align_start), 64'd0);

    // R5: no search while request low, even on a perfectly aligned stream
    do_reset(1'b0);
    gate_watch = 1'b1;
    for (int k = 0; k < 4; k++) send_word(ALIGN, 1'b0);
    idle(3);
    gate_watch = 1'b0;

    // R2/R3/R4/R8: directed and random starting offsets
    run_trial(0);
    run_trial(1);
    run_trial(33);
    for (int t = 0; t < 3; t++) run_trial(int'($urandom % 34));

    // R7: bad-word run handling while locked
    for (int k = 0; k < 3; k++) begin
      w = {2'b11, 32'(k)};
      exp_q.push_back(w);
      send_word(w, 1'b0);
    end
    w = {2'b01, 32'h1234_5678};
    exp_q.push_back(w);
    send_word(w, 1'b0);
    for (int k = 0; k < 3; k++) begin
      w = {2'b11, 32'(k + 16)};
      exp_q.push_back(w);
      send_word(w, 1'b0);
    end
    idle(3);
    check(rx_ok_n == 1'b0, "R7 good word clears run", 64'(rx_ok_n), 64'd0);
    w = {2'b11, 32'hDEAD_0004};
    exp_q.push_back(w);
    send_word(w, 1'b0);
    idle(3);
    check(rx_ok_n == 1'b1, "R7 four bad words drop lock", 64'(rx_ok_n), 64'd1);
    send_word(ALIGN, 1'b0);
    send_word(ALIGN, 1'b0);
    idle(3);
    check(rx_ok_n == 1'b0, "R7 search restarts and relocks", 64'(rx_ok_n), 64'd0);
    idle(6);
    check(exp_q.size() == 0, "R7 words delivered", 64'(exp_q.size()), 64'd0);

    // R9: back-pressure drops newer words, keeps the held one
    bp_force = 1'b1;
    wa = {2'b00, 32'hA0A0_0001};
    wb = {2'b01, 32'hB0B0_0002};
    wc = {2'b10, 32'hC0C0_0003};
    exp_q.push_back(wa);
    send_word(wa, 1'b0);
    send_word(wb, 1'b0);
    send_word(wc, 1'b0);
    idle(3);
    check(out_valid == 1'b1, "R9 held valid", 64'(out_valid), 64'd1);
    check({out_type, out_data} == wa, "R9 held word kept", 64'({out_type, out_data}), 64'(wa));
    bp_force = 1'b0;
    low_run = 8;
    idle(3);
    check(out_valid == 1'b0, "R9 drained after accept", 64'(out_valid), 64'd0);
    check(exp_q.size() == 0, "R9 held word accepted", 64'(exp_q.size()), 64'd0);
    wd = {2'b10, 32'hD0D0_0004};
    exp_q.push_back(wd);
    send_word(wd, 1'b0);
    idle(12);
    check(exp_q.size() == 0, "R9 next word delivered", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule